// File: doc/BRIEF.md
# Activity Monitor with Consecutive and Average Watermarks

The block measures traffic on one source. Each activity pulse adds a programmable weight to a period accumulator. At every period tick the closing count is folded into a running average with a power-of-two window, and the accumulator starts again from zero. The closing count is compared against an upper and a lower raw threshold. A separate run counter per threshold raises a sticky status flag once the breach has lasted a programmed number of back-to-back periods. The new average is compared against its own pair of thresholds, and each comparison can also set a flag.

Software programs the thresholds, weight, window and run lengths through a 32-bit register port, preloads the average and reads it back, and clears flags by writing ones. One interrupt line is the OR of the flags, each gated by its own enable bit.

Top module: `act_mon`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While the monitor is active, each cycle with `event_i` high adds the weight register (0x18) to the accumulator, saturating at all ones. A pulse in the same cycle as `tick_i` counts toward the period that is closing. The accumulator restarts from zero after each tick.
- R3: On an active tick the average becomes avg + ((count - avg) >>> (K+1)), using signed arithmetic, where K is control bits [12:10]. This gives a window of 2^(K+1) periods.
- R4: A write to 0x1C preloads the average. The average reads back at 0x20.
- R5: When control bit 30 is set, a closing count above the upper threshold (0x08) for N back-to-back periods sets status bit 31, where N is control bits [28:26] plus one. The run restarts after any period without a breach and after it fires.
- R6: When control bit 29 is set, a closing count below the lower threshold (0x0C) for N back-to-back periods sets status bit 30, where N is control bits [25:23] plus one. The run restarts in the same two cases as in R5.
- R7: On an active tick, a new average above 0x10 sets status bit 29 when control bit 21 is set. A new average below 0x14 sets status bit 28 when control bit 20 is set.
- R8: Status (0x04) clears bit by bit when ones are written to it. A flag set in the same cycle takes priority over the clear.
- R9: `irq_o` is high when any status bit is set together with its enable: bit 31 with control 30, bit 30 with control 29, bit 29 with control 21, bit 28 with control 20.
- R10: The monitor is active only when control bits 31 and 18 are both set. When it is inactive, events and ticks are ignored, the accumulator and the run counters are cleared, and the average and status are left untouched. Writing 0 to control (0x00) stops the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| tick_i | input | 1 | End-of-period pulse |
| event_i | input | 1 | Activity pulse |
| irq_o | output | 1 | Interrupt |

## Verification
Each window setting K = 0 to 3 is tried with the same sequence of period event counts, rising and falling. Both directions are used so that the arithmetic shift on a negative difference can be told apart from a logical shift, and so that a wrong window shows up as a wrong average. The run counters are tried with two patterns:
- breach runs broken by a quiet period, which separates "back-to-back" from "cumulative";
- repeated runs after a flag has fired, which shows that the count restarts.

Saturating weights, a pulse on the tick cycle, and the stopped and half-enabled control states each probe a single edge of the datapath.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int unsigned AW = 6;
  localparam logic [AW-1:0] A_CTRL = 6'h00;
  localparam logic [AW-1:0] A_STAT = 6'h04;
  localparam logic [AW-1:0] A_HI   = 6'h08;
  localparam logic [AW-1:0] A_LO   = 6'h0C;
  localparam logic [AW-1:0] A_AHI  = 6'h10;
  localparam logic [AW-1:0] A_ALO  = 6'h14;
  localparam logic [AW-1:0] A_WGT  = 6'h18;
  localparam logic [AW-1:0] A_INIT = 6'h1C;
  localparam logic [AW-1:0] A_AVG  = 6'h20;

  localparam int unsigned C_ENA    = 31;
  localparam int unsigned C_UP_EN  = 30;
  localparam int unsigned C_DN_EN  = 29;
  localparam int unsigned C_UP_N   = 26;
  localparam int unsigned C_DN_N   = 23;
  localparam int unsigned C_AUP_EN = 21;
  localparam int unsigned C_ADN_EN = 20;
  localparam int unsigned C_PER    = 18;
  localparam int unsigned C_K      = 10;
  localparam int unsigned NW       = 3;
  localparam int unsigned KW       = 3;

  // status nibble maps to register bits 31..28
  localparam int unsigned S_LSB    = 28;
  typedef struct packed {
    logic up;
    logic dn;
    logic aup;
    logic adn;
  } stat_t;
endpackage

// File: rtl/act_mon_avg.sv
module act_mon_avg #(
  parameter int unsigned DW = 32,
  parameter int unsigned KW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          event_i,
  input  logic          tick_i,
  input  logic [DW-1:0] weight_i,
  input  logic [KW-1:0] k_i,
  input  logic          init_we_i,
  input  logic [DW-1:0] init_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] avg_o,
  output logic [DW-1:0] avg_next_o
);
  localparam int unsigned SW = KW + 1;

  logic [DW-1:0]   acc_q, avg_q;
  logic [DW:0]     sum;
  logic signed [DW:0] diff, step;
  logic [SW-1:0]   sh;

  always_comb begin
    sum        = {1'b0, acc_q} + {1'b0, (event_i ? weight_i : '0)};
    count_o    = sum[DW] ? '1 : sum[DW-1:0];
    diff       = $signed({1'b0, count_o}) - $signed({1'b0, avg_q});
    sh         = SW'(k_i) + SW'(1);
    step       = diff >>> sh;
    avg_next_o = avg_q + step[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      avg_q <= '0;
    end else begin
      if (!active_i || tick_i) acc_q <= '0;
      else                     acc_q <= count_o;
      if (init_we_i)                avg_q <= init_i;
      else if (active_i && tick_i)  avg_q <= avg_next_o;
    end
  end

  assign acc_o = acc_q;
  assign avg_o = avg_q;
endmodule

// File: rtl/act_mon_run.sv
module act_mon_run #(
  parameter int unsigned NW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          breach_i,
  input  logic [NW-1:0] need_i,
  output logic          fire_o
);
  logic [NW-1:0] run_q;

  assign fire_o = !clr_i && tick_i && breach_i && (run_q == need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (clr_i)                run_q <= '0;
    else if (tick_i) begin
      if (!breach_i || fire_o)     run_q <= '0;
      else                         run_q <= run_q + NW'(1);
    end
  end
endmodule

// File: rtl/act_mon.sv
module act_mon
  import act_mon_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          tick_i,
  input  logic          event_i,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, hi_q, lo_q, ahi_q, alo_q, wgt_q;
  stat_t         stat_q, stat_set, stat_clr;
  logic [DW-1:0] count, acc, avg, avg_next;
  logic          active, act_tick;
  logic [1:0]    breach, run_en, fire;
  logic [NW-1:0] need [2];

  assign active   = ctrl_q[C_ENA] && ctrl_q[C_PER];
  assign act_tick = active && tick_i;

  act_mon_avg #(.DW(DW), .KW(KW)) u_avg (
    .clk_i, .rst_ni,
    .active_i   (active),
    .event_i,
    .tick_i,
    .weight_i   (wgt_q),
    .k_i        (ctrl_q[C_K +: KW]),
    .init_we_i  (reg_wr_i && reg_addr_i == A_INIT),
    .init_i     (reg_wdata_i),
    .count_o    (count),
    .acc_o      (acc),
    .avg_o      (avg),
    .avg_next_o (avg_next)
  );

  // index 0: upper threshold, index 1: lower threshold
  assign breach[0] = count > hi_q;
  assign breach[1] = count < lo_q;
  assign run_en[0] = ctrl_q[C_UP_EN];
  assign run_en[1] = ctrl_q[C_DN_EN];
  assign need[0]   = ctrl_q[C_UP_N +: NW];
  assign need[1]   = ctrl_q[C_DN_N +: NW];

  for (genvar g = 0; g < 2; g++) begin : g_run
    act_mon_run #(.NW(NW)) u_run (
      .clk_i, .rst_ni,
      .clr_i    (!active || !run_en[g]),
      .tick_i   (tick_i),
      .breach_i (breach[g]),
      .need_i   (need[g]),
      .fire_o   (fire[g])
    );
  end

  always_comb begin
    stat_set.up  = fire[0];
    stat_set.dn  = fire[1];
    stat_set.aup = act_tick && ctrl_q[C_AUP_EN] && (avg_next > ahi_q);
    stat_set.adn = act_tick && ctrl_q[C_ADN_EN] && (avg_next < alo_q);
    stat_clr     = (reg_wr_i && reg_addr_i == A_STAT) ? reg_wdata_i[DW-1:S_LSB] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; hi_q <= '0; lo_q <= '0;
      ahi_q  <= '0; alo_q <= '0; wgt_q <= '0;
      stat_q <= '0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CTRL:  ctrl_q <= reg_wdata_i;
          A_HI:    hi_q   <= reg_wdata_i;
          A_LO:    lo_q   <= reg_wdata_i;
          A_AHI:   ahi_q  <= reg_wdata_i;
          A_ALO:   alo_q  <= reg_wdata_i;
          A_WGT:   wgt_q  <= reg_wdata_i;
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_STAT:  reg_rdata_o = {stat_q, {S_LSB{1'b0}}};
      A_HI:    reg_rdata_o = hi_q;
      A_LO:    reg_rdata_o = lo_q;
      A_AHI:   reg_rdata_o = ahi_q;
      A_ALO:   reg_rdata_o = alo_q;
      A_WGT:   reg_rdata_o = wgt_q;
      A_AVG:   reg_rdata_o = avg;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & {ctrl_q[C_UP_EN], ctrl_q[C_DN_EN],
                             ctrl_q[C_AUP_EN], ctrl_q[C_ADN_EN]});
endmodule

// File: rtl/act_mon_chk.sv
module act_mon_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [5:0]    reg_addr_i,
  input logic          tick_i,
  input logic          irq_o,
  input logic          active,
  input logic [DW-1:0] ctrl_q,
  input logic [3:0]    stat_q,
  input logic [DW-1:0] avg,
  input logic [DW-1:0] acc
);
  // R10
  stop_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q == '0) |-> !irq_o);
  // R10
  idle_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (acc == '0));
  // R3
  avg_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(avg) |-> $past((tick_i && active) || (reg_wr_i && reg_addr_i == 6'h1C)));
  // R5
  up_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[3]) |-> $past(tick_i && active && ctrl_q[30]));
  // R7
  adn_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> $past(tick_i && active && ctrl_q[20]));
endmodule

bind act_mon act_mon_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .tick_i, .irq_o,
  .active, .ctrl_q, .stat_q, .avg, .acc
);

// File: tb/act_mon_test.sv
module act_mon_test;
  localparam time TCLK = 10ns;
  localparam logic [31:0] ENA = 32'h8000_0000, PER = 32'h0004_0000;

  logic        clk_i = 0, rst_ni = 0, reg_wr_i = 0, tick_i = 0, event_i = 0;
  logic [5:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic        irq_o;
  int checks = 0, fails = 0;
  bit done = 0;
  longint mavg = 0;
  int mk = 0;
  longint mw = 4;

  act_mon uut (.*);

  always #(TCLK/2) clk_i = ~clk_i;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_wr_i = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  // n pulses, then a tick (optionally with a pulse); model tracks the average
  task automatic period(int n, bit on_tick, bit act);
    longint cnt, d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); event_i = 1;
    end
    @(negedge clk_i); event_i = on_tick; tick_i = 1;
    @(negedge clk_i); event_i = 0; tick_i = 0;
    cnt = mw * (n + on_tick);
    if (cnt > 64'hFFFF_FFFF) cnt = 64'hFFFF_FFFF;
    if (act) begin
      d = cnt - mavg;
      mavg = mavg + (d >>> (mk + 1));
    end
  endtask

  function automatic logic [31:0] ctl(int k, logic [31:0] extra);
    return ENA | PER | (32'(k) << 10) | extra;
  endfunction

  logic [31:0] v;
  int ev[5] = '{0, 3, 10, 25, 7};

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h20, v); check("R1 avg", v, 0);
    rd(6'h04, v); check("R1 stat", v, 0);
    check("R1 irq", irq_o, 0);

    wr(6'h18, 4); mw = 4;
    wr(6'h08, 32'hFFFF_FFFF);
    // R4 preload
    wr(6'h1C, 100); mavg = 100;
    rd(6'h20, v); check("R4 preload", v, 100);

    // R3 / R2 window sweep
    for (int k = 0; k < 4; k++) begin
      mk = k;
      wr(6'h00, ctl(k, 0));
      wr(6'h1C, 100); mavg = 100;
      foreach (ev[i]) begin
        period(ev[i], 0, 1);
        rd(6'h20, v); check($sformatf("R3 K=%0d n=%0d", k, ev[i]), v, mavg);
      end
    end
    // R2 pulse on tick cycle
    mk = 0; wr(6'h00, ctl(0, 0)); wr(6'h1C, 0); mavg = 0;
    period(5, 1, 1); rd(6'h20, v); check("R2 tick pulse", v, 12);
    // R2 saturation
    wr(6'h18, 32'hFFFF_FFF0); mw = 64'hFFFF_FFF0; wr(6'h1C, 0); mavg = 0;
    period(2, 0, 1); rd(6'h20, v); check("R2 saturate", v, 32'h7FFF_FFFF);
    wr(6'h18, 4); mw = 4; wr(6'h1C, 0); mavg = 0;

    // R5 upper run N=2
    wr(6'h08, 30); wr(6'h0C, 0);
    wr(6'h00, ctl(0, (1 << 30) | (1 << 26)));
    period(10, 0, 1); rd(6'h04, v); check("R5 one breach", v, 0);
    period(2, 0, 1);  rd(6'h04, v); check("R5 broken run", v, 0);
    period(10, 0, 1); rd(6'h04, v); check("R5 restart", v, 0);
    period(10, 0, 1); rd(6'h04, v); check("R5 fire", v, 32'h8000_0000);
    check("R9 irq up", irq_o, 1);
    wr(6'h04, 32'hFFFF_FFFF);
    period(10, 0, 1); rd(6'h04, v); check("R5 reset after fire", v, 0);
    period(10, 0, 1); rd(6'h04, v); check("R5 refire", v, 32'h8000_0000);
    wr(6'h04, 32'hFFFF_FFFF);

    // R6 lower run N=3
    wr(6'h0C, 20);
    wr(6'h00, ctl(0, (1 << 30) | (1 << 26) | (1 << 29) | (2 << 23)));
    period(2, 0, 1); period(2, 0, 1);
    rd(6'h04, v); check("R6 two breaches", v, 0);
    period(2, 0, 1); rd(6'h04, v); check("R6 fire", v, 32'h4000_0000);
    // R8 selective clear
    period(10, 0, 1); period(10, 0, 1);
    rd(6'h04, v); check("R8 both set", v, 32'hC000_0000);
    wr(6'h04, 32'h8000_0000);
    rd(6'h04, v); check("R8 clear one", v, 32'h4000_0000);
    // R9 gating
    wr(6'h00, ctl(0, (1 << 30)));
    check("R9 masked", irq_o, 0);
    rd(6'h04, v); check("R9 stat kept", v, 32'h4000_0000);
    wr(6'h00, ctl(0, (1 << 29)));
    check("R9 unmasked", irq_o, 1);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); check("R8 clear all", v, 0);

    // R7 average thresholds
    wr(6'h0C, 0); wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h10, 60); wr(6'h14, 20);
    wr(6'h00, ctl(0, (1 << 21) | (1 << 20)));
    wr(6'h1C, 50); mavg = 50;
    period(20, 0, 1); rd(6'h04, v); check("R7 above", v, 32'h2000_0000);
    check("R9 irq aup", irq_o, 1);
    period(5, 0, 1); rd(6'h20, v); check("R7 avg", v, mavg);
    wr(6'h04, 32'hFFFF_FFFF);
    period(0, 0, 1); rd(6'h04, v); check("R7 not below", v, 0);
    period(0, 0, 1); rd(6'h04, v); check("R7 below", v, 32'h1000_0000);
    rd(6'h20, v); check("R7 avg low", v, mavg);

    // R10 stop and half-enable
    wr(6'h00, 0);
    check("R10 irq off", irq_o, 0);
    period(10, 0, 0); rd(6'h20, v); check("R10 avg frozen", v, mavg);
    rd(6'h04, v); check("R10 stat kept", v, 32'h1000_0000);
    wr(6'h00, ENA | (1 << 21));
    period(30, 0, 0); rd(6'h20, v); check("R10 no periodic", v, mavg);
    rd(6'h04, v); check("R10 no flag", v, 32'h1000_0000);
    wr(6'h00, ctl(0, 0));
    period(0, 0, 1); rd(6'h20, v); check("R10 acc cleared", v, mavg);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule